// File: doc/BRIEF.md
# Blit Buffer Address Generator with Line Buffer

This block sits between a graphics blit engine and an on-chip scratchpad RAM. The engine issues 32-bit read or write requests and names one of two buffers. It never supplies an address. Each buffer has a base register and a pointer register. A request uses the chosen buffer's pointer as its scratchpad byte address, and the pointer then steps forward by one dword. When a blit finishes, the engine pulses an end strobe, and the pointer of that buffer reloads from its base. The same buffer area can then serve the next blit without software writing the pointer again.

A 16-byte line buffer sits between the requests and the array, so the array is touched about once per line. Reads that fall in the held line are answered from the buffer. A read that misses first fetches the whole line. Writes gather in the buffer and go to the array as one masked line write at one of three points: when the last dword of a line is written, when a write moves to another line, or when the end strobe arrives. Software loads the base and pointer registers through a simple write port. A register write always takes the cycle, and a request waits behind it. The scratchpad is a synchronous RAM outside the block, one 128-bit line wide, with a per-dword write mask and one cycle of read latency. With a 2, 3 or 4 KB scratchpad, each blit buffer is 816, 1328 or 1840 bytes long. The base registers set where each buffer lies.

Top module: `blt_line_buf`

## Requirements
- R1: While reset is asserted and after it is released, rsp_valid and ram_en are low. The line buffer then holds no line, so the first read is treated as a miss.
- R2: When reg_wr_en is high, reg_wr_data is written to a register of buffer reg_wr_sel: the pointer when reg_wr_ptr is 1, the base when it is 0. The new value is used by the next request or reload. These registers have no reset value.
- R3: An accepted request (req_valid and req_ready both high) uses the pointer of buffer req_buf as its byte address. The pointer then advances by 4 and wraps modulo 2^ADDR_W.
- R4: A pulse on eob_valid reloads the pointer of buffer eob_buf from that buffer's base. If a register write to the same pointer happens in the same cycle, the register write wins. A reload wins over the advance of a request accepted in the same cycle.
- R5: A read to the line held in the buffer is a hit when that line was fetched from the array. A hit is accepted in its first cycle and makes no RAM access. One cycle later rsp_valid is high and rsp_rdata holds the dword selected by address bits [3:2] of the line at address bits [ADDR_W-1:4].
- R6: A read miss while no buffered write is pending makes one RAM read with ram_addr equal to byte address >> 4. req_ready stays low for two cycles, and the request is then served as a hit.
- R7: A write is accepted without a RAM write unless it targets word index 3. In that case the line is written to the array in the same cycle. ram_wmask bit w marks each dword w written to that line since the last array write, and ram_wdata bits [32w+31:32w] carry dword w.
- R8: A write to a line other than the buffered one, while buffered writes are pending, first writes the old line to the array with its mask. req_ready is low during that cycle, and the write is accepted in the next cycle.
- R9: After an end strobe, pending buffered writes are written to the array within two cycles.
- R10: req_ready is low in every cycle where reg_wr_en is high.
- R11: A read to a line that is not held as fetched, while buffered writes are pending, first writes those dwords to the array and then fetches the line. req_ready stays low for three cycles, and the data returned includes any dword written before.
- R12: rsp_valid is high only in the cycle after a read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | SEL_W | Buffer whose register is written |
| reg_wr_ptr | input | 1 | 1 writes the pointer, 0 writes the base |
| reg_wr_data | input | ADDR_W | Byte address to load |
| req_valid | input | 1 | Blit request present |
| req_write | input | 1 | 1 for a dword write, 0 for a read |
| req_buf | input | SEL_W | Buffer used by the request |
| req_wdata | input | DATA_W | Write dword |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read dword |
| eob_valid | input | 1 | End-of-blit pulse |
| eob_buf | input | SEL_W | Buffer whose pointer reloads |
| ram_en | output | 1 | Scratchpad access |
| ram_we | output | 1 | Access is a write |
| ram_addr | output | ADDR_W-4 | Line address |
| ram_wmask | output | 4 | Per-dword write enables |
| ram_wdata | output | 128 | Line write data |
| ram_rdata | input | 128 | Line read data, one cycle after a read |

## Verification
Some rules hold on every cycle and are checked there. A register write always stalls the request. A response comes only one cycle after an accepted read, and a hit never touches the array. A line fetch is always followed by a stall cycle, and no array write ever has an empty mask. A write-back caused by a line change or a miss stalls the request. The pointer steps by one dword after each accepted request that is not overridden by a reload. The bench scenarios are needed to show the rest: that the returned data matches the memory contents, that partial lines merge without disturbing the unwritten dwords, that the end strobe reloads from the base and writes back pending data, that pointers wrap, and the exact stall counts for a miss and for a write-back followed by a fetch.

// File: rtl/blt_pkg.sv
package blt_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} blt_state_e;
  localparam int unsigned BLT_NBUF = 2;
endpackage

// File: rtl/blt_ptr_regs.sv
module blt_ptr_regs #(
  parameter int ADDR_W = 12,
  parameter int NBUF   = 2,
  parameter int STEP   = 4,
  localparam int SEL_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_is_ptr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              eob_en,
  input  logic [SEL_W-1:0]  eob_sel,
  input  logic              inc_en,
  input  logic [SEL_W-1:0]  inc_sel,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_ptr
);
  function automatic logic [ADDR_W-1:0] ptr_advance(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(STEP);
  endfunction

  logic [ADDR_W-1:0] base_q [NBUF];
  logic [ADDR_W-1:0] ptr_q  [NBUF];

  // no reset: software loads both registers before first use
  always_ff @(posedge clk) begin
    for (int i = 0; i < NBUF; i++) begin
      if (wr_en && !wr_is_ptr && wr_sel == SEL_W'(i)) base_q[i] <= wr_data;
      if (wr_en && wr_is_ptr && wr_sel == SEL_W'(i))  ptr_q[i] <= wr_data;
      else if (eob_en && eob_sel == SEL_W'(i))        ptr_q[i] <= base_q[i];
      else if (inc_en && inc_sel == SEL_W'(i))        ptr_q[i] <= ptr_advance(ptr_q[i]);
    end
  end

  assign rd_ptr = ptr_q[rd_sel];
endmodule

// File: rtl/blt_line_store.sv
module blt_line_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 8,
  localparam int WO_W   = $clog2(WORDS),
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put_en,
  input  logic [WO_W-1:0]   put_wo,
  input  logic [DATA_W-1:0] put_data,
  input  logic              put_retag,
  input  logic              put_clean,
  input  logic [TAG_W-1:0]  put_tag,
  input  logic              evict_en,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  output logic [TAG_W-1:0]  tag,
  output logic              full,
  output logic [WORDS-1:0]  mask,
  output logic [WORDS-1:0]  put_mask,
  output logic [LINE_W-1:0] data,
  output logic [LINE_W-1:0] merged
);
  function automatic logic [WORDS-1:0] wo_bit(input logic [WO_W-1:0] w);
    return WORDS'(1) << w;
  endfunction

  logic [TAG_W-1:0] tag_q;
  logic             full_q;
  logic [WORDS-1:0] mask_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (fill_en)                              word_q <= fill_data[g*DATA_W +: DATA_W];
      else if (put_en && put_wo == WO_W'(g))    word_q <= put_data;
    end
    assign data[g*DATA_W +: DATA_W]   = word_q;
    assign merged[g*DATA_W +: DATA_W] = (put_wo == WO_W'(g)) ? put_data : word_q;
  end

  assign put_mask = (put_retag ? '0 : mask_q) | wo_bit(put_wo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      full_q <= 1'b0;
      mask_q <= '0;
    end else if (fill_en) begin
      tag_q  <= fill_tag;
      full_q <= 1'b1;
    end else if (put_en) begin
      if (put_retag) begin
        tag_q  <= put_tag;
        full_q <= 1'b0;
      end
      mask_q <= put_clean ? '0 : put_mask;
    end else if (evict_en) begin
      mask_q <= '0;
    end
  end

  assign tag  = tag_q;
  assign full = full_q;
  assign mask = mask_q;
endmodule

// File: rtl/blt_line_buf.sv
module blt_line_buf
  import blt_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NBUF       = BLT_NBUF,
  localparam int SEL_W       = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int BYTES_PER_W = DATA_W / 8,
  localparam int WO_LSB      = $clog2(BYTES_PER_W),
  localparam int LINE_LSB    = $clog2(LINE_BYTES),
  localparam int WORDS       = LINE_BYTES / BYTES_PER_W,
  localparam int WO_W        = $clog2(WORDS),
  localparam int TAG_W       = ADDR_W - LINE_LSB,
  localparam int LINE_W      = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [SEL_W-1:0]  reg_wr_sel,
  input  logic              reg_wr_ptr,
  input  logic [ADDR_W-1:0] reg_wr_data,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_buf,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              eob_valid,
  input  logic [SEL_W-1:0]  eob_buf,
  output logic              ram_en,
  output logic              ram_we,
  output logic [TAG_W-1:0]  ram_addr,
  output logic [WORDS-1:0]  ram_wmask,
  output logic [LINE_W-1:0] ram_wdata,
  input  logic [LINE_W-1:0] ram_rdata
);
  function automatic logic [TAG_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_LSB];
  endfunction
  function automatic logic [WO_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[LINE_LSB-1:WO_LSB];
  endfunction
  function automatic logic [DATA_W-1:0] word_pick(input logic [LINE_W-1:0] l,
                                                  input logic [WO_W-1:0] w);
    return l[w*DATA_W +: DATA_W];
  endfunction

  // named events shared with the checker
  logic [ADDR_W-1:0] req_addr;
  logic              evict, fill, rd_fetch, rd_accept, wr_accept, last_put;
  logic              unused_lsb;

  blt_state_e       state_q;
  logic [TAG_W-1:0] fill_tag_q;
  logic             flush_pend_q;
  logic             rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic [TAG_W-1:0]  lb_tag;
  logic              lb_full;
  logic [WORDS-1:0]  lb_mask, put_mask;
  logic [LINE_W-1:0] lb_data, lb_merged;

  logic [TAG_W-1:0] a_tag;
  logic [WO_W-1:0]  a_wo;
  logic same_line, hit, dirty, idle, do_pflush, act, wr_conflict, rd_flush;

  blt_ptr_regs #(.ADDR_W(ADDR_W), .NBUF(NBUF), .STEP(BYTES_PER_W)) u_regs (
    .clk(clk), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_is_ptr(reg_wr_ptr),
    .wr_data(reg_wr_data), .eob_en(eob_valid), .eob_sel(eob_buf),
    .inc_en(rd_accept || wr_accept), .inc_sel(req_buf), .rd_sel(req_buf),
    .rd_ptr(req_addr)
  );

  assign unused_lsb = ^req_addr[WO_LSB-1:0];
  assign a_tag      = line_of(req_addr);
  assign a_wo       = word_of(req_addr);

  assign same_line   = (a_tag == lb_tag);
  assign hit         = lb_full && same_line;
  assign dirty       = |lb_mask;
  assign idle        = (state_q == ST_IDLE);
  assign fill        = (state_q == ST_FILL);
  assign do_pflush   = idle && !reg_wr_en && flush_pend_q;
  assign act         = idle && !reg_wr_en && !flush_pend_q && req_valid;
  assign wr_conflict = act && req_write && dirty && !same_line;
  assign rd_flush    = act && !req_write && !hit && dirty;
  assign rd_fetch    = act && !req_write && !hit && !dirty;
  assign wr_accept   = act && req_write && !wr_conflict;
  assign rd_accept   = act && !req_write && hit;
  assign evict       = wr_conflict || rd_flush || (do_pflush && dirty);
  assign last_put    = wr_accept && (a_wo == WO_W'(WORDS-1));

  blt_line_store #(.DATA_W(DATA_W), .WORDS(WORDS), .TAG_W(TAG_W)) u_line (
    .clk(clk), .rst_n(rst_n),
    .put_en(wr_accept), .put_wo(a_wo), .put_data(req_wdata),
    .put_retag(!same_line), .put_clean(last_put), .put_tag(a_tag),
    .evict_en(evict), .fill_en(fill), .fill_tag(fill_tag_q), .fill_data(ram_rdata),
    .tag(lb_tag), .full(lb_full), .mask(lb_mask), .put_mask(put_mask),
    .data(lb_data), .merged(lb_merged)
  );

  assign ram_en    = evict || rd_fetch || last_put;
  assign ram_we    = evict || last_put;
  assign ram_addr  = (rd_fetch || last_put) ? a_tag : lb_tag;
  assign ram_wmask = last_put ? put_mask : lb_mask;
  assign ram_wdata = last_put ? lb_merged : lb_data;
  assign req_ready = rd_accept || wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      fill_tag_q   <= '0;
      flush_pend_q <= 1'b0;
      rsp_valid_q  <= 1'b0;
    end else begin
      if (rd_fetch) begin
        state_q    <= ST_FILL;
        fill_tag_q <= a_tag;
      end else if (fill) begin
        state_q <= ST_IDLE;
      end
      if (eob_valid)      flush_pend_q <= 1'b1;
      else if (do_pflush) flush_pend_q <= 1'b0;
      rsp_valid_q <= rd_accept;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_accept) rsp_rdata_q <= word_pick(lb_data, a_wo);
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/blt_line_buf_chk.sv
module blt_line_buf_chk #(
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 1,
  parameter int WORDS  = 4,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              req_valid,
  input logic              req_write,
  input logic [SEL_W-1:0]  req_buf,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              eob_valid,
  input logic [SEL_W-1:0]  eob_buf,
  input logic              ram_en,
  input logic              ram_we,
  input logic [WORDS-1:0]  ram_wmask,
  input logic [ADDR_W-1:0] req_addr,
  input logic              evict,
  input logic              fill
);
  logic rd_acc, any_acc;
  assign rd_acc  = req_valid && req_ready && !req_write;
  assign any_acc = req_valid && req_ready;

  assert_regwr_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !req_ready);

  assert_rsp_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  assert_no_stray_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);

  assert_hit_no_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> !ram_en);

  assert_fetch_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |=> (fill && !req_ready));

  assert_write_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |-> (ram_wmask != '0));

  assert_evict_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> (ram_en && ram_we && !req_ready));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !(eob_valid && eob_buf == req_buf)) |=>
      ($stable(req_buf) |-> (req_addr == $past(req_addr) + ADDR_W'(STEP))));
endmodule

bind blt_line_buf blt_line_buf_chk #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .WORDS(WORDS), .STEP(BYTES_PER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .req_valid(req_valid),
  .req_write(req_write), .req_buf(req_buf), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .eob_valid(eob_valid), .eob_buf(eob_buf),
  .ram_en(ram_en), .ram_we(ram_we), .ram_wmask(ram_wmask),
  .req_addr(req_addr), .evict(evict), .fill(fill)
);

// File: tb/tb_blt_line_buf.sv
`timescale 1ns/1ps
module tb_blt_line_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 0, reg_wr_sel = 0, reg_wr_ptr = 0;
  logic [11:0] reg_wr_data = '0;
  logic req_valid = 0, req_write = 0, req_buf = 0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic eob_valid = 0, eob_buf = 0;
  logic ram_en, ram_we;
  logic [7:0] ram_addr;
  logic [3:0] ram_wmask;
  logic [127:0] ram_wdata, ram_rdata;

  always #4 clk = ~clk;

  blt_line_buf dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_ptr(reg_wr_ptr), .reg_wr_data(reg_wr_data), .req_valid(req_valid),
    .req_write(req_write), .req_buf(req_buf), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .eob_valid(eob_valid), .eob_buf(eob_buf), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wmask(ram_wmask), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [127:0] mem [256];
  logic [31:0]  ref_dw [1024];
  logic [11:0]  exp_ptr [2];
  logic [31:0]  exp_q [$];

  function automatic logic [31:0] seed(input int i);
    return 32'h5A00_0000 ^ (i * 32'h0001_0003);
  endfunction

  // scratchpad model
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) begin
        wr_cnt++;
        for (int w = 0; w < 4; w++)
          if (ram_wmask[w]) mem[ram_addr][w*32 +: 32] <= ram_wdata[w*32 +: 32];
      end else begin
        rd_cnt++;
        ram_rdata <= mem[ram_addr];
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R12", "response without read", rsp_rdata, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata === e, "R5 R11", "read data", rsp_rdata, e);
      end
    end
  end

  task automatic reg_write(input logic b, input logic is_ptr, input logic [11:0] v);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = b; reg_wr_ptr = is_ptr; reg_wr_data = v;
    @(posedge clk);
    #1 reg_wr_en = 0;
    if (is_ptr) exp_ptr[b] = v;
  endtask

  task automatic do_req(input logic b, input logic w, input logic [31:0] d, output int waits);
    logic [9:0] idx;
    @(negedge clk);
    req_valid = 1; req_write = w; req_buf = b; req_wdata = d; waits = 0;
    #1;
    while (!req_ready) begin waits++; @(negedge clk); #1; end
    @(posedge clk);
    idx = exp_ptr[b][11:2];
    if (w) ref_dw[idx] = d; else exp_q.push_back(ref_dw[idx]);
    exp_ptr[b] = exp_ptr[b] + 12'd4;
    #1 req_valid = 0; req_write = 0;
  endtask

  task automatic pulse_eob(input logic b);
    @(negedge clk);
    eob_valid = 1; eob_buf = b;
    @(posedge clk);
    #1 eob_valid = 0;
    exp_ptr[b] = (b == 0) ? 12'h000 : 12'h400;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int waits, r0, w0;
    for (int i = 0; i < 1024; i++) begin
      ref_dw[i] = seed(i);
      mem[i/4][(i%4)*32 +: 32] = seed(i);
    end
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && ram_en == 0, "R1", "outputs in reset", {30'b0, rsp_valid, ram_en}, 0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0 && ram_en == 0, "R1", "outputs after reset", {30'b0, rsp_valid, ram_en}, 0);

    // R2: program both buffers
    reg_write(0, 0, 12'h000); reg_write(0, 1, 12'h000);
    reg_write(1, 0, 12'h400); reg_write(1, 1, 12'h400);

    // R6 / R5: sequential reads, one fetch per line
    r0 = rd_cnt;
    do_req(0, 0, 0, waits);
    check(waits == 2, "R6", "miss stall cycles", waits, 2);
    for (int k = 1; k < 8; k++) begin
      do_req(0, 0, 0, waits);
      if (k == 4) check(waits == 2, "R6", "second line miss stall", waits, 2);
      if (k == 5) check(waits == 0, "R5", "hit stall cycles", waits, 0);
    end
    check(rd_cnt - r0 == 2, "R5 R6", "array reads for two lines", rd_cnt - r0, 2);

    // R7: gather a full line on buffer 1
    w0 = wr_cnt;
    for (int k = 0; k < 3; k++) do_req(1, 1, 32'hB000_0000 + k, waits);
    @(negedge clk);
    check(wr_cnt == w0, "R7", "no array write before last word", wr_cnt - w0, 0);
    do_req(1, 1, 32'hB000_0003, waits);
    @(negedge clk);
    check(wr_cnt - w0 == 1, "R7", "one line write", wr_cnt - w0, 1);
    check(mem[8'h40][31:0] == 32'hB000_0000, "R7", "word 0 stored", mem[8'h40][31:0], 32'hB000_0000);
    check(mem[8'h40][127:96] == 32'hB000_0003, "R7", "word 3 stored", mem[8'h40][127:96], 32'hB000_0003);

    // R8: partial line then line change through the other buffer
    do_req(1, 1, 32'hC000_0000, waits);
    do_req(1, 1, 32'hC000_0001, waits);
    do_req(0, 1, 32'hD000_0000, waits);
    check(waits == 1, "R8", "write-back stall", waits, 1);
    @(negedge clk);
    check(mem[8'h41][63:32] == 32'hC000_0001, "R8", "dirty word written", mem[8'h41][63:32], 32'hC000_0001);
    check(mem[8'h41][95:64] == seed(32'h106), "R8", "clean word untouched", mem[8'h41][95:64], seed(32'h106));

    // R9 / R4: end strobe writes back and reloads pointer 0
    pulse_eob(0);
    repeat (2) @(negedge clk);
    check(mem[8'h02][31:0] == 32'hD000_0000, "R9", "flush on end strobe", mem[8'h02][31:0], 32'hD000_0000);
    do_req(0, 0, 0, waits);  // R4: reads base address 0

    // R11: dirty line then read miss through buffer 0
    reg_write(1, 1, 12'h500);
    do_req(1, 1, 32'hE000_0005, waits);
    reg_write(0, 1, 12'h500);
    do_req(0, 0, 0, waits);
    check(waits == 3, "R11", "flush plus fetch stall", waits, 3);

    // R10: register write and request in the same cycle
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = 0; reg_wr_ptr = 1; reg_wr_data = 12'h600;
    req_valid = 1; req_write = 0; req_buf = 0;
    #1 check(req_ready == 0, "R10", "stall during register write", {31'b0, req_ready}, 0);
    @(posedge clk);
    #1 reg_wr_en = 0; req_valid = 0;
    exp_ptr[0] = 12'h600;
    do_req(0, 0, 0, waits);  // R2: new pointer used

    // R3: pointer wraps at the top of the address space
    reg_write(0, 1, 12'hFFC);
    do_req(0, 0, 0, waits);
    do_req(0, 0, 0, waits);
    check(exp_ptr[0] == 12'h004, "R3", "model pointer wrapped", {20'b0, exp_ptr[0]}, 32'h004);

    // R4: register write beats reload in the same cycle
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = 1; reg_wr_ptr = 1; reg_wr_data = 12'h100;
    eob_valid = 1; eob_buf = 1;
    @(posedge clk);
    #1 reg_wr_en = 0; eob_valid = 0;
    exp_ptr[1] = 12'h100;
    do_req(1, 0, 0, waits);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 R12", "all reads answered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule